// File: doc/BRIEF.md
# Buffered UART Transmitter with Low-Water Interrupt

This block is the transmit half of a serial port. Software pushes bytes into a 64-deep queue through a write port. A serialiser takes them one at a time and sends each as an 8N1 frame on the `txd` line. Bit timing comes from a baud tick that fires once every R+1 clocks. Each bit lasts 14 of those ticks, so one bit is (R+1)*14 clocks long.

The current queue occupancy is published in the upper byte of a 16-bit level word. A latched status bit records the moment the occupancy drops to a programmable low-water mark. That bit drives an interrupt line through an enable, and software clears it by writing a one.

A control bit forces a break: the line stays low for as long as the bit is set. After a break the line is held at the idle level for one full bit time before queued traffic resumes.

Top module: `uart_txlw`

## Requirements
- R1: `level_q[15:8]` holds the number of bytes stored in the queue, from 0 to 64, and `level_q[7:0]` always reads zero. A byte written on `tx_we` is counted from the next clock.
- R2: A byte written while the queue holds 64 entries is discarded. The stored entries are left as they were and are later sent unchanged and in order.
- R3: Each queued byte is sent in write order as a frame: one low start bit, then eight data bits least-significant first, then one high stop bit. Every bit lasts 14*(R+1) clocks, where R is the value last written on the rate port. The line rests high between frames.
- R4: The status bit `ist_q` sets when the condition "occupancy <= mark" changes from false to true. The mark is chosen by `ctl_q[1:0]`: 0 gives 0 bytes, 1 gives 4, 2 gives 8 and 3 gives 16. The bit then stays set until `ist_we` is pulsed with `ist_wdata`=1. A pulse with `ist_wdata`=0 has no effect. A new set event in the same cycle as a clear wins over the clear.
- R5: `irq` equals the status bit gated by the enable `ctl_q[5]`. The status bit sets whether or not the enable is on.
- R6: While `ctl_q[8]` is 1, `txd` is driven low and no new frame is taken from the queue, so the occupancy does not fall.
- R7: After `ctl_q[8]` returns to 0, `txd` stays high for at least 14*(R+1) clocks before the next start bit.
- R8: After reset, `txd` is high, the occupancy is zero, `ist_q` and `irq` are low, the control word is zero and R is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_we | input | 1 | Push strobe for the transmit queue |
| tx_wdata | input | 8 | Byte to push |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 9 | New control word ([1:0] mark, [5] irq enable, [8] break) |
| ctl_q | output | 9 | Current control word |
| rate_we | input | 1 | Rate divider write strobe |
| rate_wdata | input | 8 | Divider value R |
| ist_we | input | 1 | Status write strobe |
| ist_wdata | input | 1 | 1 clears the status bit, 0 does nothing |
| ist_q | output | 1 | Latched low-water status |
| level_q | output | 16 | Occupancy in [15:8], zero in [7:0] |
| irq | output | 1 | Interrupt request |
| txd | output | 1 | Serial output, idle high |

## Verification
A push, a control write or a status clear is visible on `level_q`, `ctl_q` or `ist_q` on the first clock after the strobe. The bench drives inputs on falling edges and reads at the next falling edge. A status set comes one clock after the occupancy reaches the mark. The bench therefore waits for the falling edge where `level_q` first shows the mark, checks that the status is still low there, and expects it set one edge later.

Frames are checked by a monitor that sees the start edge and then samples each bit near its centre: 13 clocks in for the start bit and every 28 clocks after that at R=1. The break recovery gap is measured in clocks from the release write to the first start edge.

// File: rtl/uart_txlw_pkg.sv
// Shared types and constants for the buffered UART transmitter.
// Assumes 8N1 framing and a 14x oversampled bit period.
package uart_txlw_pkg;

    // Serialiser states
    typedef enum logic [2:0] {
        SH_IDLE,
        SH_START,
        SH_DATA,
        SH_STOP,
        SH_GUARD
    } sh_state_t;

    localparam int OSR     = 14;   // baud ticks per bit
    localparam int CTL_W   = 9;    // control word width
    localparam int BIT_IEN = 5;    // interrupt enable bit
    localparam int BIT_BRK = 8;    // break force bit
    localparam int LVL_W   = 8;    // width of the level field

    // Low-water mark in bytes for a 2-bit selector
    function automatic logic [LVL_W-1:0] mark_bytes(input logic [1:0] sel);
        case (sel)
            2'd0:    return 8'd0;
            2'd1:    return 8'd4;
            2'd2:    return 8'd8;
            default: return 8'd16;
        endcase
    endfunction

endpackage

// File: rtl/txlw_baud.sv
// Baud tick generator: one tick every RATE+1 clocks.
// Assumes the rate may change at any time; a lowered rate takes effect
// at once because the counter compares with >=.
module txlw_baud #(
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);

    logic [RATE_W-1:0] div_cnt;

    assign tick = (div_cnt >= rate);

    // Free-running divider counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt <= '0;
        end else if (tick) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/txlw_fifo.sv
// Byte queue with occupancy count.
// A push on a full queue and a pop on an empty queue are both ignored.
module txlw_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [DW-1:0]              din,
    input  logic                       pop,
    output logic [DW-1:0]              dout,
    output logic [$clog2(DEPTH+1)-1:0] count
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign do_push = push && (count < CW'(DEPTH));
    assign do_pop  = pop && (count != '0);
    assign dout    = mem[rp];

    // Storage write; entries need no reset
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wp] <= din;
        end
    end

    // Pointer and occupancy bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) begin
                wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            end
            if (do_pop) begin
                rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/txlw_shifter.sv
// Frame serialiser: start, DW data bits LSB first, stop, each OSR ticks.
// Assumes the baud tick is a single-clock pulse. Frames start only on a
// tick, so every bit is exactly OSR ticks. After a break it inserts one
// idle bit time before the next frame.
module txlw_shifter
    import uart_txlw_pkg::*;
#(
    parameter int DW  = 8,
    parameter int NSR = OSR
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          brk,
    input  logic          have_data,
    input  logic [DW-1:0] din,
    output logic          pop,
    output logic          line
);

    localparam int SW = $clog2(NSR);
    localparam int BW = (DW > 1) ? $clog2(DW) : 1;

    sh_state_t     state;
    logic [SW-1:0] sub;
    logic [BW-1:0] bit_idx;
    logic [DW-1:0] shreg;
    logic          brk_seen;
    logic          bit_end;

    assign bit_end = tick && (sub == SW'(NSR - 1));
    assign pop     = have_data && !brk && !brk_seen &&
                     ((state == SH_IDLE && tick) || (state == SH_STOP && bit_end));

    // Frame sequencing and line drive
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SH_IDLE;
            sub      <= '0;
            bit_idx  <= '0;
            shreg    <= '0;
            brk_seen <= 1'b0;
            line     <= 1'b1;
        end else begin
            if (brk) begin
                brk_seen <= 1'b1;
            end
            if (tick && state != SH_IDLE) begin
                sub <= bit_end ? '0 : sub + 1'b1;
            end
            case (state)
                SH_IDLE: begin
                    sub <= '0;
                    if (!brk && brk_seen) begin
                        brk_seen <= 1'b0;
                        line     <= 1'b1;
                        state    <= SH_GUARD;
                    end else if (pop) begin
                        shreg <= din;
                        line  <= 1'b0;
                        state <= SH_START;
                    end
                end
                SH_START: begin
                    if (bit_end) begin
                        line    <= shreg[0];
                        bit_idx <= '0;
                        state   <= SH_DATA;
                    end
                end
                SH_DATA: begin
                    if (bit_end) begin
                        if (bit_idx == BW'(DW - 1)) begin
                            line  <= 1'b1;
                            state <= SH_STOP;
                        end else begin
                            shreg   <= shreg >> 1;
                            line    <= shreg[1];
                            bit_idx <= bit_idx + 1'b1;
                        end
                    end
                end
                SH_STOP: begin
                    if (bit_end) begin
                        if (pop) begin
                            shreg <= din;
                            line  <= 1'b0;
                            state <= SH_START;
                        end else begin
                            state <= SH_IDLE;
                        end
                    end
                end
                SH_GUARD: begin
                    line <= 1'b1;
                    if (bit_end) begin
                        state <= SH_IDLE;
                    end
                end
                default: state <= SH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/uart_txlw.sv
// Buffered UART transmitter top: queue, baud tick, serialiser, control
// word, rate register and latched low-water status with interrupt.
// Assumes DEPTH fits the 8-bit level field.
module uart_txlw
    import uart_txlw_pkg::*;
#(
    parameter int              DEPTH    = 64,
    parameter int              DW       = 8,
    parameter int              RATE_W   = 8,
    parameter logic [RATE_W-1:0] RATE_RST = {RATE_W{1'b1}}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_we,
    input  logic [DW-1:0]     tx_wdata,
    input  logic              ctl_we,
    input  logic [CTL_W-1:0]  ctl_wdata,
    output logic [CTL_W-1:0]  ctl_q,
    input  logic              rate_we,
    input  logic [RATE_W-1:0] rate_wdata,
    input  logic              ist_we,
    input  logic              ist_wdata,
    output logic              ist_q,
    output logic [15:0]       level_q,
    output logic              irq,
    output logic              txd
);

    localparam int CW = $clog2(DEPTH + 1);

    logic [RATE_W-1:0] rate_q;
    logic              tick;
    logic              fifo_pop;
    logic [DW-1:0]     fifo_dout;
    logic [CW-1:0]     fifo_cnt;
    logic [LVL_W-1:0]  lvl;
    logic              sh_line;
    logic              below_mark;
    logic              below_q;
    logic              tx_evt;

    assign lvl        = LVL_W'(fifo_cnt);
    assign level_q    = {lvl, 8'h00};
    assign below_mark = (lvl <= mark_bytes(ctl_q[1:0]));
    assign tx_evt     = below_mark && !below_q;
    assign irq        = ist_q && ctl_q[BIT_IEN];
    assign txd        = ctl_q[BIT_BRK] ? 1'b0 : sh_line;

    // Control word and rate registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            rate_q <= RATE_RST;
        end else begin
            if (ctl_we)  ctl_q  <= ctl_wdata;
            if (rate_we) rate_q <= rate_wdata;
        end
    end

    // Low-water edge detection and write-1-to-clear status
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            below_q <= 1'b1;
            ist_q   <= 1'b0;
        end else begin
            below_q <= below_mark;
            if (tx_evt) begin
                ist_q <= 1'b1;
            end else if (ist_we && ist_wdata) begin
                ist_q <= 1'b0;
            end
        end
    end

    txlw_baud #(.RATE_W(RATE_W)) u_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .rate  (rate_q),
        .tick  (tick)
    );

    txlw_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (tx_we),
        .din   (tx_wdata),
        .pop   (fifo_pop),
        .dout  (fifo_dout),
        .count (fifo_cnt)
    );

    txlw_shifter #(.DW(DW), .NSR(OSR)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .brk       (ctl_q[BIT_BRK]),
        .have_data (fifo_cnt != '0),
        .din       (fifo_dout),
        .pop       (fifo_pop),
        .line      (sh_line)
    );

endmodule

// File: rtl/txlw_checker.sv
// Property checker for uart_txlw, attached by bind.
module txlw_checker #(
    parameter int DEPTH = 64
) (
    input logic        clk,
    input logic        rst_n,
    input logic        tx_we,
    input logic [15:0] level_q,
    input logic        txd,
    input logic        ist_we,
    input logic        ist_wdata,
    input logic        ist_q,
    input logic        irq,
    input logic        brk_q,
    input logic        fifo_pop,
    input logic        tx_evt
);

    AST_LVL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (level_q[15:8] <= 8'(DEPTH)) && (level_q[7:0] == 8'h00)); // R1

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (level_q[15:8] == 8'(DEPTH) && tx_we && !fifo_pop) |=> (level_q[15:8] == 8'(DEPTH))); // R2

    AST_STAT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (ist_we && ist_wdata && !tx_evt) |=> !ist_q); // R4

    AST_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ist_q && !(ist_we && ist_wdata)) |=> ist_q); // R4

    AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ist_q); // R5

    AST_BRK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        brk_q |-> !txd); // R6

    AST_BRK_NOPOP: assert property (@(posedge clk) disable iff (!rst_n)
        brk_q |-> !fifo_pop); // R6

endmodule

bind uart_txlw txlw_checker #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_we     (tx_we),
    .level_q   (level_q),
    .txd       (txd),
    .ist_we    (ist_we),
    .ist_wdata (ist_wdata),
    .ist_q     (ist_q),
    .irq       (irq),
    .brk_q     (ctl_q[8]),
    .fifo_pop  (fifo_pop),
    .tx_evt    (tx_evt)
);

// File: tb/sim_uart_txlw.sv
// Scoreboard bench: the driver queues expected bytes, the monitor decodes txd.
module sim_uart_txlw;

    localparam int BITC = 28;   // clocks per bit at R=1

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_we = 1'b0;
    logic [7:0] tx_wdata = '0;
    logic       ctl_we = 1'b0;
    logic [8:0] ctl_wdata = '0;
    logic [8:0] ctl_q;
    logic       rate_we = 1'b0;
    logic [7:0] rate_wdata = '0;
    logic       ist_we = 1'b0;
    logic       ist_wdata = 1'b0;
    logic       ist_q;
    logic [15:0] level_q;
    logic       irq;
    logic       txd;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int rx_cnt = 0;
    int first_start = -1;
    bit mon_en = 1'b0;
    logic [7:0] exp_q[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    uart_txlw u0 (
        .clk(clk), .rst_n(rst_n),
        .tx_we(tx_we), .tx_wdata(tx_wdata),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_q(ctl_q),
        .rate_we(rate_we), .rate_wdata(rate_wdata),
        .ist_we(ist_we), .ist_wdata(ist_wdata), .ist_q(ist_q),
        .level_q(level_q), .irq(irq), .txd(txd)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push_byte(input logic [7:0] b, input bit accept);
        @(negedge clk);
        tx_we = 1'b1; tx_wdata = b;
        @(negedge clk);
        tx_we = 1'b0;
        if (accept) exp_q.push_back(b);
    endtask

    task automatic wr_ctl(input logic [8:0] v);
        @(negedge clk);
        ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic wr_ist(input logic v);
        @(negedge clk);
        ist_we = 1'b1; ist_wdata = v;
        @(negedge clk);
        ist_we = 1'b0;
    endtask

    // Monitor: decode frames from txd and compare with the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (mon_en && txd === 1'b0) begin
                logic [7:0] got;
                if (first_start < 0) first_start = cyc;
                repeat (13) @(negedge clk);
                chk(txd === 1'b0, "R3 start bit", int'(txd), 0);
                for (int k = 0; k < 8; k++) begin
                    repeat (BITC) @(negedge clk);
                    got[k] = txd;
                end
                repeat (BITC) @(negedge clk);
                chk(txd === 1'b1, "R3 stop bit", int'(txd), 1);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3 unexpected frame", int'(got), 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(got == e, "R3 frame data", int'(got), int'(e));
                end
                rx_cnt++;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R3 watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int rel_cyc;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        chk(txd === 1'b1, "R8 txd", int'(txd), 1);
        chk(level_q === 16'h0, "R8 level", int'(level_q), 0);
        chk(ist_q === 1'b0 && irq === 1'b0, "R8 status", int'({ist_q, irq}), 0);
        chk(ctl_q === 9'h0, "R8 ctl", int'(ctl_q), 0);

        // Rate R=1; break on, mark 4, irq enabled
        @(negedge clk); rate_we = 1'b1; rate_wdata = 8'd1;
        @(negedge clk); rate_we = 1'b0;
        wr_ctl(9'h100 | 9'h020 | 9'h001);
        wr_ist(1'b1);
        chk(txd === 1'b0, "R6 break drives low", int'(txd), 0);

        // Fill during break: 66 writes, the last two dropped
        for (int i = 0; i < 66; i++) begin
            push_byte(8'((i * 37 + 5) & 8'hFF), i < 64);
            if (i == 9) begin
                @(negedge clk);
                chk(level_q[15:8] == 8'd10, "R1 level count", int'(level_q[15:8]), 10);
                chk(level_q[7:0] == 8'h00, "R1 low byte", int'(level_q[7:0]), 0);
            end
        end
        @(negedge clk);
        chk(level_q[15:8] == 8'd64, "R2 full drop", int'(level_q[15:8]), 64);
        repeat (100) @(negedge clk);
        chk(level_q[15:8] == 8'd64, "R6 no pop in break", int'(level_q[15:8]), 64);
        chk(txd === 1'b0, "R6 line held low", int'(txd), 0);
        chk(ist_q === 1'b0, "R4 no event while filling", int'(ist_q), 0);

        // Release break and start monitoring
        wr_ctl(9'h020 | 9'h001);
        rel_cyc = cyc;
        mon_en = 1'b1;

        // Low-water event at 4 bytes
        while (level_q[15:8] != 8'd4) @(negedge clk);
        chk(ist_q === 1'b0, "R4 status one cycle later", int'(ist_q), 0);
        @(negedge clk);
        chk(ist_q === 1'b1, "R4 status set at mark", int'(ist_q), 1);
        chk(irq === 1'b1, "R5 irq enabled", int'(irq), 1);
        chk(first_start - rel_cyc >= BITC, "R7 idle gap after break",
            first_start - rel_cyc, BITC);
        wr_ist(1'b0);
        chk(ist_q === 1'b1, "R4 write zero ignored", int'(ist_q), 1);
        wr_ist(1'b1);
        chk(ist_q === 1'b0 && irq === 1'b0, "R4 write one clears",
            int'({ist_q, irq}), 0);

        while (exp_q.size() != 0) @(negedge clk);
        repeat (400) @(negedge clk);
        chk(rx_cnt == 64, "R2 all stored bytes sent", rx_cnt, 64);
        chk(ist_q === 1'b0, "R4 no repeat below mark", int'(ist_q), 0);

        // R5: mark 0, enable off; status sets, irq stays low
        wr_ctl(9'h000);
        wr_ist(1'b1);
        push_byte(8'h00, 1'b1);
        push_byte(8'hFF, 1'b1);
        push_byte(8'hA5, 1'b1);
        while (level_q[15:8] != 8'd0) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(ist_q === 1'b1, "R5 status without enable", int'(ist_q), 1);
        chk(irq === 1'b0, "R5 irq masked", int'(irq), 0);
        wr_ctl(9'h020);
        chk(irq === 1'b1, "R5 irq after enable", int'(irq), 1);

        while (exp_q.size() != 0) @(negedge clk);
        repeat (400) @(negedge clk);
        chk(rx_cnt == 67, "R3 total frames", rx_cnt, 67);
        chk(txd === 1'b1, "R3 idle high", int'(txd), 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule